// File: doc/BRIEF.md
# Byte-Synchronous Message Transmitter

This block serialises character-oriented synchronous messages one bit per clock, least significant bit first, eight clocks per character. A message opens with a programmable SYNC character, repeated for as long as the start-of-message control stays high. Once that control drops, the block sends characters from a single holding register. On end-of-message it can append a 16-bit CRC over the data characters. It keeps sending SYNC characters while end-of-message stays high, and returns to a marked line when that control is released.

Per-character odd parity can replace the top data bit. If the host fails to refill the holding register in time, an underrun is flagged and the line is filled until a new start-of-message. A turnaround sequence of sixteen space bits follows a SYNC that was sent with both start and end controls set, once both are cleared.

The host works at character boundaries. It changes the controls or loads the holding register while a character is on the line. The block samples the controls on the clock edge that ends the last bit of the current character, and that sample picks the next character.

Top module: `byte_sync_tx`

## Requirements
- R1: While idle, `tx_som` and `tx_en` high at a clock edge make `tx_active` rise at that edge, and the first bit of `sync_char` appears on `txd`. Every character takes 8 clocks and is sent LSB first. A SYNC is sent at each boundary where `tx_som` is high.
- R2: `buf_empty` is high when `tx_active` is high and the holding register holds no character. A `hold_wr` pulse makes `buf_empty` low in the following cycle.
- R3: At a boundary with `tx_som` low, a loaded holding character is sent as the next character, and the holding register becomes empty.
- R4: At a boundary with `tx_som` and `tx_eom` low, the holding register empty and no underrun pending, `tx_urun` sets. From then on every character is fill: `sync_char` when `fill_sync` is 1, 8'hFF when it is 0. The holding register is left untouched until a boundary with `tx_som` high sends a SYNC and clears `tx_urun`.
- R5: With `crc_en` high, `tx_eom` high and the holding register empty, the block sends the CRC low byte and then the high byte. The CRC is CRC-16 with polynomial x^16+x^15+x^2+1, zero preset and reflected bit order. It covers every data character as transmitted since the last SYNC sent under `tx_som`.
- R6: After the CRC, or immediately when `crc_en` is low, the block sends SYNC characters while `tx_eom` stays high. A boundary in this trailer with `tx_eom` low ends the message and `tx_active` falls.
- R7: Clearing `tx_eom` and `tx_en` during the CRC low byte still sends the CRC high byte. No SYNC follows, and the line goes idle.
- R8: Outside a CRC pair and a space sequence, a boundary with `tx_en` low makes `tx_active` fall.
- R9: With `vrc_en` high, a data character goes out as its low 7 bits followed by an odd parity bit in bit position 7.
- R10: A SYNC sent with `tx_som` and `tx_eom` both high, followed by a boundary with both low, produces exactly 16 zero bits.
- R11: After reset `txd` is 1, and `tx_active`, `buf_empty` and `tx_urun` are 0.
- R12: `txd` is 1 whenever `tx_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| tx_som | input | 1 | Start-of-message control |
| tx_eom | input | 1 | End-of-message control |
| hold_wr | input | 1 | Load strobe for the holding register |
| hold_din | input | 8 | Character to load |
| sync_char | input | 8 | Programmable SYNC character |
| crc_en | input | 1 | Append CRC-16 on end-of-message |
| vrc_en | input | 1 | Odd parity in bit 7 of data characters |
| fill_sync | input | 1 | Underrun fill: 1 SYNC, 0 all ones |
| txd | output | 1 | Serial line |
| tx_active | output | 1 | Transmitter busy |
| buf_empty | output | 1 | Holding register may be loaded |
| tx_urun | output | 1 | Underrun status |

## Verification
The control sample taken at the edge that ends bit 7 of character k selects character k+1. That choice shows on `txd` from the same edge, so `tx_urun` is visible during the first bit of character k+1, and `buf_empty` falls one cycle after a write. The bench drives controls and writes only at the falling edge inside bit 0 of character k, so each action takes effect on character k+1. It records `txd` at every falling edge while `tx_active` is high and compares the recorded stream in 8-bit groups with a character list built from the requirements. Status outputs are sampled at falling edges one bit into the affected character.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int unsigned CHAR_W   = 8;
    localparam int unsigned CRC_W    = 16;
    localparam logic [CRC_W-1:0] CRC_POLY_REF = 16'hA001;

    typedef logic [CHAR_W-1:0] char_t;
    typedef logic [CRC_W-1:0]  crc_t;

    typedef enum logic [2:0] {
        K_SYNC   = 3'd0,
        K_DATA   = 3'd1,
        K_CRC_LO = 3'd2,
        K_CRC_HI = 3'd3,
        K_SPACE  = 3'd4,
        K_FILL   = 3'd5
    } kind_e;

    typedef struct packed {
        logic  load;     // start a new character this edge
        logic  stop;     // hold the line marked
        kind_e kind;     // which source feeds the new character
        logic  take;     // holding register consumed
        logic  crc_clr;  // restart CRC accumulation
        logic  crc_upd;  // fold the new character into the CRC
    } step_t;

    function automatic crc_t crc_char(input crc_t c, input char_t d);
        crc_t r;
        r = c;
        for (int i = 0; i < int'(CHAR_W); i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REF;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic char_t vrc_char(input char_t d);
        return {~^d[CHAR_W-2:0], d[CHAR_W-2:0]};
    endfunction

endpackage

// File: rtl/txs_crc.sv
module txs_crc
    import txs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  upd,
    input  char_t din,
    output crc_t  crc_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc_q <= '0;
        else if (upd)   crc_q <= crc_char(crc_q, din);
    end
endmodule

// File: rtl/txs_ser.sv
module txs_ser
    import txs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  stop,
    input  char_t val,
    output logic  txd,
    output logic  last_bit
);
    localparam int unsigned CNT_W = $clog2(CHAR_W);

    char_t            sh_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            sh_q  <= '1;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= val;
            cnt_q <= '0;
        end else begin
            sh_q  <= {1'b1, sh_q[CHAR_W-1:1]};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign txd      = sh_q[0];
    assign last_bit = (cnt_q == CNT_W'(CHAR_W - 1));
endmodule

// File: rtl/txs_seq.sv
module txs_seq
    import txs_pkg::*;
#(
    parameter int unsigned SPACE_CHARS = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tx_en,
    input  logic  som,
    input  logic  eom,
    input  logic  crc_en,
    input  logic  hold_full,
    input  logic  last_bit,
    output logic  active,
    output logic  urun,
    output step_t step
);
    localparam int unsigned SPC_W = $clog2(SPACE_CHARS + 1);

    logic             hi_pend, hi_n;
    logic [SPC_W-1:0] spc_left, spc_n;
    logic             arm, arm_n;
    logic             trailer, trailer_n;
    logic             crc_sent, sent_n;
    logic             active_n, urun_n;
    logic             begin_msg;

    always_comb begin
        step      = '0;
        begin_msg = 1'b0;
        active_n  = active;
        urun_n    = urun;
        hi_n      = hi_pend;
        spc_n     = spc_left;
        arm_n     = arm;
        trailer_n = trailer;
        sent_n    = crc_sent;
        if (!active) begin
            if (tx_en && som) begin_msg = 1'b1;
            else              step.stop = 1'b1;
        end else if (last_bit) begin
            if (hi_pend) begin
                step.load = 1'b1; step.kind = K_CRC_HI; hi_n = 1'b0;
            end else if (spc_left != '0) begin
                step.load = 1'b1; step.kind = K_SPACE; spc_n = spc_left - 1'b1;
            end else if (!tx_en || (trailer && !eom)) begin
                step.stop = 1'b1;
                active_n  = 1'b0;
                trailer_n = 1'b0;
                arm_n     = 1'b0;
            end else if (som) begin
                begin_msg = 1'b1;
            end else begin
                arm_n = 1'b0;
                if (arm && !eom) begin
                    step.load = 1'b1; step.kind = K_SPACE;
                    spc_n = SPC_W'(SPACE_CHARS - 1);
                end else if (urun) begin
                    step.load = 1'b1; step.kind = K_FILL;
                end else if (hold_full) begin
                    step.load = 1'b1; step.kind = K_DATA;
                    step.take = 1'b1; step.crc_upd = 1'b1;
                end else if (eom) begin
                    trailer_n = 1'b1;
                    step.load = 1'b1;
                    if (crc_en && !crc_sent) begin
                        step.kind = K_CRC_LO; hi_n = 1'b1; sent_n = 1'b1;
                    end else begin
                        step.kind = K_SYNC;
                    end
                end else begin
                    urun_n = 1'b1;
                    step.load = 1'b1; step.kind = K_FILL;
                end
            end
        end
        if (begin_msg) begin
            step.load    = 1'b1;
            step.kind    = K_SYNC;
            step.crc_clr = 1'b1;
            active_n     = 1'b1;
            urun_n       = 1'b0;
            trailer_n    = 1'b0;
            sent_n       = 1'b0;
            arm_n        = eom;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            urun     <= 1'b0;
            hi_pend  <= 1'b0;
            spc_left <= '0;
            arm      <= 1'b0;
            trailer  <= 1'b0;
            crc_sent <= 1'b0;
        end else begin
            active   <= active_n;
            urun     <= urun_n;
            hi_pend  <= hi_n;
            spc_left <= spc_n;
            arm      <= arm_n;
            trailer  <= trailer_n;
            crc_sent <= sent_n;
        end
    end

    assert_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(som && tx_en));
    assert_urun_set_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(urun) |-> $past(active && !som && !eom));
    assert_urun_clear_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(urun) |-> $past(som));
endmodule

// File: rtl/byte_sync_tx.sv
module byte_sync_tx
    import txs_pkg::*;
#(
    parameter int unsigned SPACE_CHARS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       tx_som,
    input  logic       tx_eom,
    input  logic       hold_wr,
    input  logic [7:0] hold_din,
    input  logic [7:0] sync_char,
    input  logic       crc_en,
    input  logic       vrc_en,
    input  logic       fill_sync,
    output logic       txd,
    output logic       tx_active,
    output logic       buf_empty,
    output logic       tx_urun
);
    step_t step;
    char_t hold_q, ld_val;
    logic  hold_full, last_bit;
    crc_t  crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else if (hold_wr) begin
            hold_full <= 1'b1;
            hold_q    <= hold_din;
        end else if (step.take) begin
            hold_full <= 1'b0;
        end
    end

    always_comb begin
        unique case (step.kind)
            K_SYNC:   ld_val = sync_char;
            K_DATA:   ld_val = vrc_en ? vrc_char(hold_q) : hold_q;
            K_CRC_LO: ld_val = crc_q[CHAR_W-1:0];
            K_CRC_HI: ld_val = crc_q[CRC_W-1:CHAR_W];
            K_SPACE:  ld_val = '0;
            K_FILL:   ld_val = fill_sync ? sync_char : '1;
            default:  ld_val = '1;
        endcase
    end

    txs_seq #(.SPACE_CHARS(SPACE_CHARS)) u_seq (
        .clk(clk), .rst(rst), .tx_en(tx_en), .som(tx_som), .eom(tx_eom),
        .crc_en(crc_en), .hold_full(hold_full), .last_bit(last_bit),
        .active(tx_active), .urun(tx_urun), .step(step)
    );

    txs_crc u_crc (
        .clk(clk), .rst(rst), .clr(step.crc_clr), .upd(step.crc_upd),
        .din(ld_val), .crc_q(crc_q)
    );

    txs_ser u_ser (
        .clk(clk), .rst(rst), .load(step.load), .stop(step.stop),
        .val(ld_val), .txd(txd), .last_bit(last_bit)
    );

    assign buf_empty = tx_active && !hold_full;

    assert_mark_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> txd);
    assert_write_fills_R2: assert property (@(posedge clk) disable iff (rst)
        hold_wr |=> !buf_empty);
    assert_parity_odd_R9: assert property (@(posedge clk) disable iff (rst)
        (step.load && step.kind == K_DATA && vrc_en) |-> ($countones(ld_val) % 2 == 1));
endmodule

// File: tb/sim_byte_sync_tx.sv
`timescale 1ns/1ps
module sim_byte_sync_tx;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 0, tx_som = 0, tx_eom = 0, hold_wr = 0;
    logic [7:0] hold_din = 0, sync_char = 8'h32;
    logic crc_en = 0, vrc_en = 0, fill_sync = 0;
    logic txd, tx_active, buf_empty, tx_urun;

    int checks = 0, fails = 0, nb = 0, base = 0;
    logic bits [0:16383];
    logic [7:0] expq[$];

    always #5 clk = ~clk;

    byte_sync_tx u0 (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_som(tx_som), .tx_eom(tx_eom),
        .hold_wr(hold_wr), .hold_din(hold_din), .sync_char(sync_char),
        .crc_en(crc_en), .vrc_en(vrc_en), .fill_sync(fill_sync),
        .txd(txd), .tx_active(tx_active), .buf_empty(buf_empty), .tx_urun(tx_urun)
    );

    always @(negedge clk) if (tx_active) begin
        bits[nb % 16384] = txd;
        nb = nb + 1;
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = r >> 1;
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_vrc(input logic [7:0] d);
        return {~(^d[6:0]), d[6:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic start_msg(input logic eom0);
        @(negedge clk);
        base = nb;
        expq.delete();
        tx_som = 1; tx_en = 1; tx_eom = eom0;
    endtask

    task automatic wchar(input int k);
        wait (nb >= base + 8*k + 1);
    endtask

    task automatic wr(input logic [7:0] d);
        hold_din = d; hold_wr = 1;
        @(negedge clk);
        hold_wr = 0;
    endtask

    task automatic finish_msg(input string req);
        int n;
        do @(negedge clk); while (tx_active);
        tx_som = 0; tx_eom = 0; tx_en = 0;
        chk({req, " idle line R12"}, txd, 1);
        n = (nb - base) / 8;
        chk({req, " char count"}, n, expq.size());
        for (int j = 0; j < n && j < expq.size(); j++) begin
            logic [7:0] b;
            for (int i = 0; i < 8; i++) b[i] = bits[(base + 8*j + i) % 16384];
            chk({req, " char"}, b, expq[j]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] c;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        chk("R11 txd", txd, 1);
        chk("R11 active", tx_active, 0);
        chk("R11 buf_empty", buf_empty, 0);
        chk("R11 urun", tx_urun, 0);

        // R1 R3 R5 R6: sync, two data, CRC, one trailing SYNC
        crc_en = 1; sync_char = 8'h32;
        start_msg(0);
        wchar(0); chk("R2 empty during SYNC", buf_empty, 1);
        wchar(1); tx_som = 0; wr(8'hA5); chk("R2 write clears", buf_empty, 0);
        wchar(2); wr(8'h3C);
        wchar(3); tx_eom = 1;
        wchar(6); tx_eom = 0;
        c = ref_crc(ref_crc(16'h0, 8'hA5), 8'h3C);
        expq = '{8'h32, 8'h32, 8'hA5, 8'h3C, c[7:0], c[15:8], 8'h32};
        finish_msg("R5 R6 message");

        // R7: drop eom and enable at CRC start
        start_msg(0);
        wchar(1); tx_som = 0; wr(8'h9E);
        wchar(2); tx_eom = 1;
        wchar(3); tx_eom = 0; tx_en = 0;
        c = ref_crc(16'h0, 8'h9E);
        expq = '{8'h32, 8'h32, 8'h9E, c[7:0], c[15:8]};
        finish_msg("R7 no trailer");

        // R4: underrun, mark fill, held data untouched until som
        crc_en = 0; fill_sync = 0; sync_char = 8'h16;
        start_msg(0);
        wchar(0); tx_som = 0;
        wchar(1); chk("R4 urun set", tx_urun, 1); wr(8'h5A);
        wchar(2); tx_som = 1; chk("R4 data held", buf_empty, 0);
        wchar(3); tx_som = 0; chk("R4 urun cleared", tx_urun, 0);
        wchar(4); tx_en = 0;
        expq = '{8'h16, 8'hFF, 8'hFF, 8'h16, 8'h5A};
        finish_msg("R4 fill ones");

        // R4: SYNC fill
        fill_sync = 1;
        start_msg(0);
        wchar(0); tx_som = 0;
        wchar(1); chk("R4 urun sync fill", tx_urun, 1); tx_en = 0;
        expq = '{8'h16, 8'h16};
        finish_msg("R4 fill sync");

        // R9: odd parity
        vrc_en = 1; fill_sync = 0;
        start_msg(0);
        wchar(0); tx_som = 0; wr(8'h41);
        wchar(1); wr(8'h87);
        wchar(2); tx_eom = 1;
        wchar(3); tx_eom = 0;
        expq = '{8'h16, ref_vrc(8'h41), ref_vrc(8'h87), 8'h16};
        finish_msg("R9 parity");
        vrc_en = 0;

        // R10: sixteen spaces
        start_msg(1);
        wchar(0); tx_som = 0; tx_eom = 0;
        wchar(2); tx_en = 0;
        expq = '{8'h16, 8'h00, 8'h00};
        finish_msg("R10 spaces");

        // R8: enable dropped after first SYNC
        start_msg(0);
        wchar(0); tx_en = 0;
        expq = '{8'h16};
        finish_msg("R8 abort");

        // R3 R5 R6: random messages
        for (int it = 0; it < 8; it++) begin
            int n, t, last;
            logic [7:0] d [0:5];
            n = 1 + ($urandom % 5);
            t = $urandom % 3;
            crc_en = $urandom % 2;
            sync_char = $urandom;
            for (int i = 0; i < 6; i++) d[i] = $urandom;
            start_msg(0);
            wchar(0); tx_som = 0; wr(d[0]);
            for (int i = 1; i < n; i++) begin wchar(i); wr(d[i]); end
            wchar(n); tx_eom = 1;
            last = crc_en ? n + 2 + t : n + 1 + t;
            wchar(last); tx_eom = 0;
            expq.delete();
            expq.push_back(sync_char);
            c = 16'h0;
            for (int i = 0; i < n; i++) begin expq.push_back(d[i]); c = ref_crc(c, d[i]); end
            if (crc_en) begin expq.push_back(c[7:0]); expq.push_back(c[15:8]); end
            for (int i = 0; i < (crc_en ? t : t + 1); i++) expq.push_back(sync_char);
            finish_msg("R3 R5 R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule